// File: doc/BRIEF.md
# Frame Tick and Interrupt Router

This block produces a one-millisecond frame tick for a USB device controller and steers the controller's interrupt sources onto two processor interrupt lines. A down-counter free-runs at the system clock and fires once every `CLK_HZ / TICK_HZ` cycles. Whenever a start-of-frame token is seen on the bus, the counter is realigned to it, so the tick follows the host's frame timing.

Three sources feed sticky status flags: the frame tick, a bulk-out event and a bulk-in event. Software clears the flags by writing ones to a clear port. A select register decides, per source, whether a set flag drives the normal-priority line (`irq_o`) or the fast line (`fiq_o`). Each line is the OR of the flags routed to it. A select value with every bit set is treated as invalid. In that case every source goes to the normal line and the fast line stays low.

Top module: `frame_irq_router`

## Requirements
- R1: While reset is held and on the first cycle after it, `sel_o` is 0, and `irq_o` and `fiq_o` are low.
- R2: With no start-of-frame pulse, `frame_tick_o` is high for one cycle exactly every PERIOD = `CLK_HZ / TICK_HZ` cycles.
- R3: In a cycle where `sof_i` is high, `frame_tick_o` is high in that same cycle. The next tick without a further pulse comes PERIOD cycles later.
- R4: Flag bit 0 is set by a frame tick, bit 1 by `src_evt_i[0]` (bulk-out) and bit 2 by `src_evt_i[1]` (bulk-in). A set flag stays set, cycle after cycle, until it is cleared.
- R5: A cycle with `clr_wr_i` high clears, from the next cycle on, each flag whose bit in `clr_wdata_i` is 1. Flags whose bit is 0 are unaffected. If a source sets its flag in the same cycle, the set wins.
- R6: A cycle with `sel_wr_i` high loads `sel_wdata_i` into the select register, and the value appears on `sel_o` in the next cycle.
- R7: When `sel_o` is not all ones, a set flag whose select bit is 0 drives `irq_o` and a set flag whose select bit is 1 drives `fiq_o`. With no set flag routed to a line, that line is low.
- R8: When `sel_o` is all ones, `fiq_o` is low and `irq_o` is high whenever any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame token seen (one-cycle pulse) |
| src_evt_i | input | NUM_SRC-1 | Non-frame source events; bit 0 bulk-out, bit 1 bulk-in |
| sel_wr_i | input | 1 | Write strobe for the select register |
| sel_wdata_i | input | NUM_SRC | Select value to write |
| clr_wr_i | input | 1 | Write strobe for the flag clear port |
| clr_wdata_i | input | NUM_SRC | Write-one-to-clear mask for the flags |
| frame_tick_o | output | 1 | One-cycle frame tick |
| irq_o | output | 1 | Normal-priority interrupt line |
| fiq_o | output | 1 | High-priority interrupt line |
| sel_o | output | NUM_SRC | Current select register value |

## Verification
Some checks run on every cycle: tick spacing is measured against PERIOD with a counter in the checker, and every start-of-frame cycle must also be a tick cycle. A written select value must appear on `sel_o` next cycle. The fast line must stay low when the select is zero or all ones, and a full clear with no competing set must leave both lines low. Other behaviour is only shown by the bench scenarios. These cover flags that persist across many idle cycles and partial clears that leave other flags alone. They also cover set-over-clear priority, and the routing of mixed flag sets for all eight select patterns. A reference model drives these against random event traffic.

// File: rtl/frt_pkg.sv
package frt_pkg;
    // Flag position driven by the frame tick; bulk sources follow above it.
    localparam int unsigned FRAME_IDX = 0;
endpackage

// File: rtl/frt_tick_gen.sv
module frt_tick_gen #(
    parameter int unsigned CLK_HZ  = 48_000_000,
    parameter int unsigned TICK_HZ = 1_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_i,
    output logic tick_o
);
    localparam int unsigned PERIOD = CLK_HZ / TICK_HZ;
    localparam int unsigned CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     tick;

    always_comb begin
        st_d = st_q;
        // A start-of-frame pulse realigns the period and ticks at once.
        tick = sof_i || (st_q.cnt == '0);
        if (tick) begin
            st_d.cnt = RELOAD;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= RELOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick;
endmodule

// File: rtl/frt_flag_bank.sv
module frt_flag_bank #(
    parameter int unsigned NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               clr_wr_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    output logic [NUM_SRC-1:0] flag_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
    } flag_st_t;

    flag_st_t           st_d, st_q;
    logic [NUM_SRC-1:0] clr_eff;

    always_comb begin
        st_d    = st_q;
        clr_eff = clr_wr_i ? clr_mask_i : '0;
        // Setting has priority over clearing in the same cycle.
        for (int i = 0; i < int'(NUM_SRC); i++) begin
            st_d.flag[i] = set_i[i] | (st_q.flag[i] & ~clr_eff[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/frt_router.sv
module frt_router #(
    parameter int unsigned NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr_i,
    input  logic [NUM_SRC-1:0] sel_wdata_i,
    input  logic [NUM_SRC-1:0] flag_i,
    output logic [NUM_SRC-1:0] sel_o,
    output logic               irq_o,
    output logic               fiq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] sel;
    } sel_st_t;

    sel_st_t            st_d, st_q;
    logic               all_fast;
    logic [NUM_SRC-1:0] fast_mask;
    logic [NUM_SRC-1:0] to_fiq;
    logic [NUM_SRC-1:0] to_irq;

    always_comb begin
        st_d = st_q;
        if (sel_wr_i) begin
            st_d.sel = sel_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // An all-ones select is rejected: nothing is sent to the fast line.
    assign all_fast  = &st_q.sel;
    assign fast_mask = all_fast ? '0 : st_q.sel;

    for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_lane
        assign to_fiq[g] = flag_i[g] &  fast_mask[g];
        assign to_irq[g] = flag_i[g] & ~fast_mask[g];
    end

    assign fiq_o = |to_fiq;
    assign irq_o = |to_irq;
    assign sel_o = st_q.sel;
endmodule

// File: rtl/frame_irq_router.sv
module frame_irq_router #(
    parameter int unsigned CLK_HZ  = 48_000_000,
    parameter int unsigned TICK_HZ = 1_000,
    parameter int unsigned NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_i,
    input  logic [NUM_SRC-2:0] src_evt_i,
    input  logic               sel_wr_i,
    input  logic [NUM_SRC-1:0] sel_wdata_i,
    input  logic               clr_wr_i,
    input  logic [NUM_SRC-1:0] clr_wdata_i,
    output logic               frame_tick_o,
    output logic               irq_o,
    output logic               fiq_o,
    output logic [NUM_SRC-1:0] sel_o
);
    import frt_pkg::*;

    logic               tick;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] flags;

    frt_tick_gen #(
        .CLK_HZ (CLK_HZ),
        .TICK_HZ(TICK_HZ)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .sof_i (sof_i),
        .tick_o(tick)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[FRAME_IDX] = tick;
        for (int i = 1; i < int'(NUM_SRC); i++) begin
            set_vec[i] = src_evt_i[i-1];
        end
    end

    frt_flag_bank #(
        .NUM_SRC(NUM_SRC)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .clr_wr_i  (clr_wr_i),
        .clr_mask_i(clr_wdata_i),
        .flag_o    (flags)
    );

    frt_router #(
        .NUM_SRC(NUM_SRC)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr_i   (sel_wr_i),
        .sel_wdata_i(sel_wdata_i),
        .flag_i     (flags),
        .sel_o      (sel_o),
        .irq_o      (irq_o),
        .fiq_o      (fiq_o)
    );

    assign frame_tick_o = tick;
endmodule

// File: rtl/frt_chk.sv
module frt_chk #(
    parameter int unsigned CLK_HZ  = 48_000_000,
    parameter int unsigned TICK_HZ = 1_000,
    parameter int unsigned NUM_SRC = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sof_i,
    input logic [NUM_SRC-2:0] src_evt_i,
    input logic               sel_wr_i,
    input logic [NUM_SRC-1:0] sel_wdata_i,
    input logic               clr_wr_i,
    input logic [NUM_SRC-1:0] clr_wdata_i,
    input logic               frame_tick_o,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] sel_o
);
    localparam int unsigned PERIOD = CLK_HZ / TICK_HZ;

    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (frame_tick_o) begin
            gap_q  <= 32'd1;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 32'd1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel_o == '0 && !irq_o && !fiq_o));

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick_o && !sof_i && seen_q) |-> (gap_q == PERIOD));

    // R3
    sof_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |-> frame_tick_o);

    // R5
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_wdata_i == '1 && src_evt_i == '0 && !frame_tick_o)
        |=> (!irq_o && !fiq_o));

    // R6
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr_i |=> (sel_o == $past(sel_wdata_i)));

    // R7
    zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == '0) |-> !fiq_o);

    // R8
    all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&sel_o) |-> !fiq_o);
endmodule

bind frame_irq_router frt_chk #(
    .CLK_HZ (CLK_HZ),
    .TICK_HZ(TICK_HZ),
    .NUM_SRC(NUM_SRC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof_i       (sof_i),
    .src_evt_i   (src_evt_i),
    .sel_wr_i    (sel_wr_i),
    .sel_wdata_i (sel_wdata_i),
    .clr_wr_i    (clr_wr_i),
    .clr_wdata_i (clr_wdata_i),
    .frame_tick_o(frame_tick_o),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .sel_o       (sel_o)
);

// File: tb/sim_frame_irq_router.sv
module sim_frame_irq_router;
    localparam int unsigned CLK_HZ  = 40_000;
    localparam int unsigned TICK_HZ = 1_000;
    localparam int unsigned NS      = 3;
    localparam int          PER     = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sof_i = 1'b0;
    logic [NS-2:0] src_evt_i = '0;
    logic          sel_wr_i = 1'b0;
    logic [NS-1:0] sel_wdata_i = '0;
    logic          clr_wr_i = 1'b0;
    logic [NS-1:0] clr_wdata_i = '0;
    logic          frame_tick_o, irq_o, fiq_o;
    logic [NS-1:0] sel_o;

    always #5 clk = ~clk;

    frame_irq_router #(
        .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .NUM_SRC(NS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .src_evt_i(src_evt_i),
        .sel_wr_i(sel_wr_i), .sel_wdata_i(sel_wdata_i),
        .clr_wr_i(clr_wr_i), .clr_wdata_i(clr_wdata_i),
        .frame_tick_o(frame_tick_o), .irq_o(irq_o), .fiq_o(fiq_o), .sel_o(sel_o)
    );

    int      total = 0;
    int      bad   = 0;
    bit      done  = 0;
    logic [NS-1:0] mflag = '0;
    logic [NS-1:0] msel  = '0;
    int      since = 0;
    bit      seen  = 0;
    string   phase = "";

    function automatic logic exp_fiq(logic [NS-1:0] f, logic [NS-1:0] s);
        logic [NS-1:0] m;
        m = (&s) ? '0 : s;
        return |(f & m);
    endfunction

    function automatic logic exp_irq(logic [NS-1:0] f, logic [NS-1:0] s);
        logic [NS-1:0] m;
        m = (&s) ? '0 : s;
        return |(f & ~m);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic sof, input logic [NS-2:0] ev,
                       input logic swr, input logic [NS-1:0] sd,
                       input logic cwr, input logic [NS-1:0] cd);
        logic  et, tk;
        string rq;
        @(negedge clk);
        sof_i = sof; src_evt_i = ev; sel_wr_i = swr; sel_wdata_i = sd;
        clr_wr_i = cwr; clr_wdata_i = cd;
        #1;
        et = sof || (since == PER);
        if (seen)
            check(frame_tick_o == et, sof ? "R3" : "R2", "frame tick",
                  int'(frame_tick_o), int'(et));
        tk = seen ? et : frame_tick_o;
        check(sel_o == msel, "R6", "select readback", int'(sel_o), int'(msel));
        rq = (&msel) ? "R8" : "R7";
        check(irq_o == exp_irq(mflag, msel), rq, {"irq line", phase},
              int'(irq_o), int'(exp_irq(mflag, msel)));
        check(fiq_o == exp_fiq(mflag, msel), rq, {"fiq line", phase},
              int'(fiq_o), int'(exp_fiq(mflag, msel)));
        // next state of the reference model at the coming edge
        if (tk) begin since = 1; seen = 1; end
        else since++;
        mflag = (mflag & ~(cwr ? cd : '0)) | {ev, tk};
        if (swr) msel = sd;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, '0, 1'b0, '0);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(sel_o == '0, "R1", "sel in reset", int'(sel_o), 0);
        check(!irq_o, "R1", "irq in reset", int'(irq_o), 0);
        check(!fiq_o, "R1", "fiq in reset", int'(fiq_o), 0);
        check(!frame_tick_o, "R1", "tick in reset", int'(frame_tick_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: free-running spacing
        phase = " R2";
        idle(4 * PER);

        // R3: realignment at several offsets, back-to-back pulses
        phase = " R3";
        idle(7);
        cyc(1'b1, '0, 1'b0, '0, 1'b0, '0);
        idle(PER / 2);
        cyc(1'b1, '0, 1'b0, '0, 1'b0, '0);
        cyc(1'b1, '0, 1'b0, '0, 1'b0, '0);
        idle(PER - 1);
        cyc(1'b1, '0, 1'b0, '0, 1'b0, '0);
        idle(2 * PER + 3);

        // R4, R5: directed sticky and clear behaviour, select 101
        phase = " R4";
        cyc(1'b0, '0, 1'b1, 3'b101, 1'b1, 3'b111);
        cyc(1'b0, 2'b01, 1'b0, '0, 1'b0, '0);
        idle(30);
        check(irq_o == 1'b1, "R4", "bulk-out flag held", int'(irq_o), 1);
        phase = " R5";
        cyc(1'b0, '0, 1'b0, '0, 1'b1, 3'b101);
        idle(1);
        check(irq_o == 1'b1, "R5", "unmasked flag kept", int'(irq_o), 1);
        cyc(1'b0, '0, 1'b0, '0, 1'b1, 3'b010);
        idle(1);
        check(irq_o == 1'b0, "R5", "flag cleared", int'(irq_o), 0);
        cyc(1'b0, 2'b01, 1'b0, '0, 1'b1, 3'b010);
        idle(1);
        check(irq_o == 1'b1, "R5", "set beats clear", int'(irq_o), 1);

        // R7, R8: every select pattern with mixed events
        for (int s = 0; s < 8; s++) begin
            phase = (s == 7) ? " R8" : " R7";
            cyc(1'b0, '0, 1'b1, 3'(s), 1'b1, 3'b111);
            for (int k = 0; k < 24; k++)
                cyc(($urandom % 16) == 0, 2'($urandom % 4), 1'b0, '0, 1'b0, '0);
            if (s == 7)
                check(fiq_o == 1'b0, "R8", "all-ones keeps fiq low", int'(fiq_o), 0);
        end

        // random mix
        phase = "";
        for (int k = 0; k < 3000; k++) begin
            logic          sf, sw, cw;
            logic [NS-2:0] ev;
            logic [NS-1:0] sd, cd;
            sf = ($urandom % 60) == 0;
            ev = {($urandom % 8) == 0, ($urandom % 8) == 0};
            sw = ($urandom % 12) == 0;
            sd = (($urandom % 4) == 0) ? 3'b111 : 3'($urandom);
            cw = ($urandom % 6) == 0;
            cd = 3'($urandom);
            cyc(sf, ev, sw, sd, cw, cd);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule